// File: doc/BRIEF.md
# Peripheral Clock Enable Sequencer

This block brings a single peripheral out of its gated state in a safe order, and gates it again on request. A request carries a clock-bit index, an optional reset-bit index and an enable/disable flag. The sequencer drives single-cycle set and clear strobes toward an external control register bank. That bank holds one bank of clock-stop bits and one bank of reset bits. The bank's current contents come back into the block as status vectors.

For an enable, the sequencer first decides whether the peripheral is already up. A peripheral that is still held in reset never counts as up. If it is up, the request completes with no write at all. Otherwise, when a reset line exists, the sequence is:

1. Hold the peripheral in reset.
2. Wait a pre-ungate interval (100 us by default).
3. Ungate its clock.
4. Wait a settle interval (10 ms by default).
5. Release reset.

Without a reset line, only the clock is ungated. A disable gates the clock immediately and leaves reset untouched. The wait intervals are counted in reference clock cycles. They are parameters derived from the clock frequency, so a bench can shorten them.

Top module: `clk_en_seq`

## Requirements
- R1: A peripheral counts as up only when its reset bit (1 = held in reset) is 0 and its clock bit is in the running state. The running state is 1 for bit INV_IDX (default 14) and 0 for every other clock bit. When there is no reset line, the reset condition is ignored.
- R2: An enable request that finds the peripheral up produces no strobe. `done_o` pulses in the second cycle after the request is accepted.
- R3: For an enable with a reset line, the cycle after acceptance carries a set strobe to the reset bank at the reset index. The clock ungate strobe follows exactly PRE_CYC+1 cycles later.
- R4: After the ungate strobe, a clear strobe to the reset bank at the reset index follows exactly POST_CYC+1 cycles later. `done_o` pulses in the next cycle.
- R5: A reset index whose most significant bit is 1 means there is no reset line. An enable then ungates the clock in the cycle after acceptance, with no reset write and no wait, and `done_o` pulses in the next cycle.
- R6: A disable request drives exactly one clock-gate strobe, in the cycle after acceptance. It never writes the reset bank. `done_o` pulses in the next cycle.
- R7: `busy_o` is high from the cycle after acceptance through the `done_o` cycle. A request presented while `busy_o` is high is ignored.
- R8: At most one strobe is active per cycle, and `done_o` lasts one cycle. While idle no strobe is driven. `wr_idx_o` and `wr_tgt_o` are 0 whenever no strobe is active.
- R9: The target field `wr_tgt_o` selects the clock bank when 0 and the reset bank when 1. `wr_set_o` writes a 1 to the addressed bit and `wr_clr_o` writes a 0. Ungating uses a clear on ordinary clock bits and a set on bit INV_IDX; gating uses the opposite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_en_i | input | 1 | 1 = enable, 0 = disable |
| req_clk_idx_i | input | CIDX_W | Clock bit index |
| req_rst_idx_i | input | RIDX_W+1 | Reset bit index; MSB set = no reset line |
| clk_stat_i | input | NCLK | Current clock-stop bank contents |
| rst_stat_i | input | NRST | Current reset bank contents |
| wr_tgt_o | output | 1 | Strobe target: 0 clock bank, 1 reset bank |
| wr_set_o | output | 1 | Set strobe |
| wr_clr_o | output | 1 | Clear strobe |
| wr_idx_o | output | IDX_W | Bit index of the strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that a request lasts one cycle and that the status vectors follow the strobes of this block alone, changing one cycle after each write. The bench keeps to this by modelling the register bank from the strobes and by driving no other writer. The bench's reference model decides "already up" from that bank at the moment of acceptance, and then expects the whole strobe schedule cycle by cycle. It covers:

- cold peripherals,
- a running clock still held in reset,
- the inverted-polarity bit,
- a high bank index,
- a request refused while busy.

// File: rtl/ces_pkg.sv
package ces_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_PRE, S_UNGATE, S_POST, S_RELEASE, S_DONE
  } ces_state_e;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_RST_ON, ACT_RST_OFF, ACT_UNGATE, ACT_GATE
  } ces_act_e;
endpackage

// File: rtl/ces_status.sv
module ces_status #(
  parameter int NCLK    = 64,
  parameter int NRST    = 64,
  parameter int CIDX_W  = 6,
  parameter int RIDX_W  = 6,
  parameter int INV_IDX = 14
) (
  input  logic [NCLK-1:0]   clk_stat_i,
  input  logic [NRST-1:0]   rst_stat_i,
  input  logic [CIDX_W-1:0] cidx_i,
  input  logic [RIDX_W-1:0] ridx_i,
  input  logic              has_rst_i,
  output logic              up_o
);
  logic in_rst, clk_run;

  assign in_rst  = has_rst_i && rst_stat_i[ridx_i];
  // one bit runs when set, all others run when clear
  assign clk_run = (cidx_i == CIDX_W'(INV_IDX)) ? clk_stat_i[cidx_i] : !clk_stat_i[cidx_i];
  assign up_o    = !in_rst && clk_run;
endmodule

// File: rtl/ces_timer.sv
module ces_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R3
  tmr_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/ces_strobe.sv
module ces_strobe
  import ces_pkg::*;
#(
  parameter int CIDX_W  = 6,
  parameter int RIDX_W  = 6,
  parameter int IDX_W   = 6,
  parameter int INV_IDX = 14
) (
  input  ces_act_e          act_i,
  input  logic [CIDX_W-1:0] cidx_i,
  input  logic [RIDX_W-1:0] ridx_i,
  output logic              tgt_o,
  output logic              set_o,
  output logic              clr_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic inv;
  assign inv = (cidx_i == CIDX_W'(INV_IDX));

  always_comb begin
    tgt_o = 1'b0;
    set_o = 1'b0;
    clr_o = 1'b0;
    idx_o = '0;
    case (act_i)
      ACT_RST_ON:  begin tgt_o = 1'b1; set_o = 1'b1; idx_o = IDX_W'(ridx_i); end
      ACT_RST_OFF: begin tgt_o = 1'b1; clr_o = 1'b1; idx_o = IDX_W'(ridx_i); end
      ACT_UNGATE:  begin set_o = inv;  clr_o = !inv; idx_o = IDX_W'(cidx_i); end
      ACT_GATE:    begin set_o = !inv; clr_o = inv;  idx_o = IDX_W'(cidx_i); end
      default: ;
    endcase
  end
endmodule

// File: rtl/clk_en_seq.sv
module clk_en_seq
  import ces_pkg::*;
#(
  parameter int NCLK     = 64,
  parameter int NRST     = 64,
  parameter int INV_IDX  = 14,
  parameter int CLK_HZ   = 125_000_000,
  parameter int PRE_CYC  = CLK_HZ / 10_000,
  parameter int POST_CYC = CLK_HZ / 100,
  parameter int CIDX_W   = $clog2(NCLK),
  parameter int RIDX_W   = $clog2(NRST),
  parameter int IDX_W    = (CIDX_W > RIDX_W) ? CIDX_W : RIDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_en_i,
  input  logic [CIDX_W-1:0] req_clk_idx_i,
  input  logic [RIDX_W:0]   req_rst_idx_i,
  input  logic [NCLK-1:0]   clk_stat_i,
  input  logic [NRST-1:0]   rst_stat_i,
  output logic              wr_tgt_o,
  output logic              wr_set_o,
  output logic              wr_clr_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int MAXC = (PRE_CYC > POST_CYC) ? PRE_CYC : POST_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef struct packed {
    logic              en;
    logic              has_rst;
    logic [CIDX_W-1:0] cidx;
    logic [RIDX_W-1:0] ridx;
  } req_t;

  ces_state_e state_q, state_d;
  ces_act_e   act;
  req_t       req_q;
  logic       up, tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      req_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && req_valid_i)
        req_q <= '{en: req_en_i, has_rst: !req_rst_idx_i[RIDX_W],
                   cidx: req_clk_idx_i, ridx: req_rst_idx_i[RIDX_W-1:0]};
    end
  end

  ces_status #(.NCLK(NCLK), .NRST(NRST), .CIDX_W(CIDX_W), .RIDX_W(RIDX_W),
               .INV_IDX(INV_IDX)) u_status (
    .clk_stat_i(clk_stat_i), .rst_stat_i(rst_stat_i),
    .cidx_i(req_q.cidx), .ridx_i(req_q.ridx), .has_rst_i(req_q.has_rst),
    .up_o(up)
  );

  ces_timer #(.CW(CW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val),
    .zero_o(tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    act      = ACT_NONE;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      S_IDLE:  if (req_valid_i) state_d = S_CHECK;
      S_CHECK: begin
        if (!req_q.en) begin
          act = ACT_GATE; state_d = S_DONE;
        end else if (up) begin
          state_d = S_DONE;
        end else if (req_q.has_rst) begin
          act = ACT_RST_ON; state_d = S_PRE;
          tmr_load = 1'b1; tmr_val = CW'(PRE_CYC - 1);
        end else begin
          act = ACT_UNGATE; state_d = S_DONE;
        end
      end
      S_PRE:     if (tmr_zero) state_d = S_UNGATE;
      S_UNGATE: begin
        act = ACT_UNGATE; state_d = S_POST;
        tmr_load = 1'b1; tmr_val = CW'(POST_CYC - 1);
      end
      S_POST:    if (tmr_zero) state_d = S_RELEASE;
      S_RELEASE: begin act = ACT_RST_OFF; state_d = S_DONE; end
      S_DONE:    state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  ces_strobe #(.CIDX_W(CIDX_W), .RIDX_W(RIDX_W), .IDX_W(IDX_W),
               .INV_IDX(INV_IDX)) u_strobe (
    .act_i(act), .cidx_i(req_q.cidx), .ridx_i(req_q.ridx),
    .tgt_o(wr_tgt_o), .set_o(wr_set_o), .clr_o(wr_clr_o), .idx_o(wr_idx_o)
  );

  assign busy_o = (state_q != S_IDLE);
  assign done_o = (state_q == S_DONE);

  // R8
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_set_o && wr_clr_o));
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R7
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(req_q));
  // R6
  dis_no_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !req_q.en) |-> !(wr_tgt_o && (wr_set_o || wr_clr_o)));
  // R4
  rel_after_post_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_tgt_o && wr_clr_o) |-> $past(state_q) == S_POST);
  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(wr_set_o || wr_clr_o));
endmodule

// File: tb/sim_clk_en_seq.sv
`timescale 1ns/1ps
module sim_clk_en_seq;
  localparam int NCLK = 64, NRST = 64, INV = 14, PRE = 5, POST = 9;
  localparam int CW = 6, RW = 6, IW = 6;

  typedef struct packed {
    logic tgt, set, clr;
    logic [IW-1:0] idx;
    logic busy, done;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_en = 1'b0;
  logic [CW-1:0] req_cidx = '0;
  logic [RW:0]   req_ridx = '0;
  logic [NCLK-1:0] cbank;
  logic [NRST-1:0] rbank;
  logic wr_tgt, wr_set, wr_clr, busy, done;
  logic [IW-1:0] wr_idx;

  int checks = 0, failures = 0;
  bit finished = 0;
  exp_t expq[$];
  string tagq[$];

  always #4 clk = ~clk;

  clk_en_seq #(.NCLK(NCLK), .NRST(NRST), .INV_IDX(INV), .PRE_CYC(PRE), .POST_CYC(POST)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_en_i(req_en),
    .req_clk_idx_i(req_cidx), .req_rst_idx_i(req_ridx),
    .clk_stat_i(cbank), .rst_stat_i(rbank),
    .wr_tgt_o(wr_tgt), .wr_set_o(wr_set), .wr_clr_o(wr_clr), .wr_idx_o(wr_idx),
    .busy_o(busy), .done_o(done)
  );

  // behavioural register bank driven only by the strobes
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cbank <= ~(64'd1 << INV);
      rbank <= '1;
    end else if (wr_set || wr_clr) begin
      if (wr_tgt) rbank[wr_idx] <= wr_set;
      else        cbank[wr_idx] <= wr_set;
    end
  end

  function automatic exp_t mk(logic t, logic s, logic c, int i, logic b, logic d);
    exp_t e;
    e.tgt = t; e.set = s; e.clr = c; e.idx = IW'(i); e.busy = b; e.done = d;
    return e;
  endfunction

  function automatic void push(exp_t e, string tag);
    expq.push_back(e);
    tagq.push_back(tag);
  endfunction

  function automatic void plan_enable(int c, bit has, int r);
    bit run = (c == INV) ? cbank[c] : !cbank[c];
    bit up  = run && (!has || !rbank[r]);
    bit inv = (c == INV);
    if (up) begin
      push(mk(0, 0, 0, 0, 1, 0), "R2");
      push(mk(0, 0, 0, 0, 1, 1), "R2");
    end else if (has) begin
      push(mk(1, 1, 0, r, 1, 0), "R3");
      for (int k = 0; k < PRE; k++) push(mk(0, 0, 0, 0, 1, 0), "R3");
      push(mk(0, inv, !inv, c, 1, 0), "R9");
      for (int k = 0; k < POST; k++) push(mk(0, 0, 0, 0, 1, 0), "R4");
      push(mk(1, 0, 1, r, 1, 0), "R4");
      push(mk(0, 0, 0, 0, 1, 1), "R4");
    end else begin
      push(mk(0, inv, !inv, c, 1, 0), "R5");
      push(mk(0, 0, 0, 0, 1, 1), "R5");
    end
  endfunction

  function automatic void plan_disable(int c);
    bit inv = (c == INV);
    push(mk(0, !inv, inv, c, 1, 0), "R6");
    push(mk(0, 0, 0, 0, 1, 1), "R6");
  endfunction

  task automatic tick();
    exp_t e, g;
    string tag;
    @(negedge clk);
    g = {wr_tgt, wr_set, wr_clr, wr_idx, busy, done};
    if (expq.size() == 0) begin
      e = '0;
      tag = "R8";
    end else begin
      e = expq.pop_front();
      tag = tagq.pop_front();
    end
    checks++;
    if (g !== e) begin
      failures++;
      $display("FAIL %s: tgt/set/clr/idx/busy/done got %b %b %b %0d %b %b exp %b %b %b %0d %b %b",
               tag, g.tgt, g.set, g.clr, g.idx, g.busy, g.done,
               e.tgt, e.set, e.clr, e.idx, e.busy, e.done);
    end
  endtask

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: got %0d exp %0d", tag, act, expv);
    end
  endtask

  // has = 0 encodes the "no reset line" index (MSB set)
  task automatic issue(bit en, int c, bit has, int r);
    req_valid = 1'b1;
    req_en    = en;
    req_cidx  = CW'(c);
    req_ridx  = has ? {1'b0, RW'(r)} : {1'b1, RW'(0)};
    if (expq.size() == 0) begin
      if (en) plan_enable(c, has, r);
      else    plan_disable(c);
    end
    tick();
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) tick();
    tick();
  endtask

  initial begin
    repeat (3) tick();                    // R8 reset state quiet
    rst_n = 1'b1;
    tick();

    issue(1, 3, 1, 6); drain();            // R3 R4 cold enable with reset
    chk(cbank[3] == 0 && rbank[6] == 0, "R4", {cbank[3], rbank[6]}, 0);
    issue(1, 3, 1, 6); drain();            // R2 already up
    issue(1, 5, 0, 0); drain();            // R5 no reset line
    chk(cbank[5] == 0, "R5", cbank[5], 0);
    issue(0, 3, 1, 6); drain();            // R6 gate only
    chk(cbank[3] == 1 && rbank[6] == 0, "R6", {cbank[3], rbank[6]}, 2);

    issue(1, 7, 0, 0); drain();            // clock 7 runs, reset 7 still held
    issue(1, 7, 1, 7); drain();            // R1 held in reset -> not up, full sequence
    chk(rbank[7] == 0, "R1", rbank[7], 0);

    issue(1, INV, 1, INV); drain();        // R9 inverted bit ungated by set
    chk(cbank[INV] == 1, "R9", cbank[INV], 1);
    issue(1, INV, 1, INV); drain();        // R1 R2 inverted bit counts as up when 1
    issue(0, INV, 1, INV); drain();        // R9 inverted bit gated by clear
    chk(cbank[INV] == 0, "R9", cbank[INV], 0);

    issue(1, 40, 1, 40);                   // high index
    tick(); tick();
    issue(0, 5, 0, 0);                     // R7 refused while busy
    drain();
    chk(cbank[5] == 0, "R7", cbank[5], 0);
    chk(cbank[40] == 0 && rbank[40] == 0, "R4", {cbank[40], rbank[40]}, 0);

    issue(1, 9, 0, 0);                     // R7 accepted right after done
    drain();
    chk(cbank[9] == 0, "R7", cbank[9], 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200_000 * 8);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule